// File: doc/BRIEF.md
# Per-Channel Integer Requantization Unit

This block sits at the output of a convolution engine. It turns wide, signed accumulated partial sums into narrow activations for the next layer, using integer arithmetic only. Each cycle it handles `LANES` output channels side by side. Every lane scales its partial sum by an integer factor that belongs to its own output channel, adds a rounding offset, shifts right arithmetically and saturates to the activation width.

The per-channel factors live in a scale store with one entry per output channel. The store is split into one bank per lane so that a block RAM can be inferred for each, and it is loaded through a plain write port. An input beat carries a valid flag, a channel-group index and `LANES` partial sums. Lane `l` of group `g` serves channel `g*LANES + l`. The shift amount and the saturation mode travel with each beat, so they may change from one beat to the next.

Top module: `requant_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid` is 0 and `out_act` is all zeros.
- R2: `out_valid` equals `in_valid` from exactly three clock edges earlier, whatever the data, and gaps in the input stream appear unchanged at the output. While `out_valid` is 0, `out_act` keeps its previous value.
- R3: Lane `l` (bits `[l*ACT_W +: ACT_W]` of `out_act`, with its partial sum in bits `[l*PSUM_W +: PSUM_W]` of `in_psum`) uses the scale stored at channel address `in_group*LANES + l`.
- R4: A write with `scale_we` high stores `scale_wdata` at channel `scale_waddr`. The write lands in bank `scale_waddr % LANES` at row `scale_waddr / LANES`. Any beat presented on a later cycle uses the new value.
- R5: The partial sum is read as two's complement and the scale as unsigned. The lane computes `(psum*scale + 2^(S-1)) >>> S`, with S = `shift_amt` (0 to 31). This rounds half up. With S = 0 no offset is added, and a zero partial sum always gives 0.
- R6: With `relu_en` = 1, the rounded value is clamped to the range 0 to 2^ACT_W-1 and output as unsigned, so negative partial sums give 0.
- R7: With `relu_en` = 0, the rounded value is clamped to the range -2^(ACT_W-1) to 2^(ACT_W-1)-1 and output as two's complement. Non-negative partial sums never give a negative output.
- R8: `shift_amt` and `relu_en` are taken with the beat that presents them. Changing them on every beat gives each beat its own rounding and saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| scale_we | input | 1 | Scale store write strobe |
| scale_waddr | input | $clog2(NUM_CH) | Output channel written |
| scale_wdata | input | SCALE_W | Unsigned integer scale |
| in_valid | input | 1 | Input beat present |
| in_group | input | $clog2(NUM_CH/LANES) | Channel-group index of the beat |
| in_psum | input | LANES*PSUM_W | Signed partial sums, lane 0 in the low bits |
| shift_amt | input | SHIFT_W | Right shift S for this beat |
| relu_en | input | 1 | 1: unsigned clamp at zero; 0: signed clamp |
| out_valid | output | 1 | Output beat present |
| out_act | output | LANES*ACT_W | Activations, lane 0 in the low bits |

## Verification
The bench uses the default parameters: 4 lanes, 24-bit partial sums, 16-bit scales, 8-bit activations, 64 channels and a 5-bit shift. With these values the full-scale product reaches 40 bits, so both saturation limits and the rounding ties at shift 1 can be reached. The 16 channel groups make a wrong bank or row selection visible, because every address holds a different scale. Including scales of 0 and 0xFFFF, together with shifts of 0 and 31, exercises the ends of the rounding path.

// File: rtl/requant_pkg.sv
package requant_pkg;
  typedef enum logic {
    MODE_SIGNED = 1'b0,
    MODE_RELU   = 1'b1
  } sat_mode_e;
endpackage

// File: rtl/requant_scale_bank.sv
module requant_scale_bank #(
  parameter int DEPTH = 16,
  parameter int AW    = 4,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/requant_lane.sv
module requant_lane
  import requant_pkg::*;
#(
  parameter int PSUM_W  = 24,
  parameter int SCALE_W = 16,
  parameter int ACT_W   = 8,
  parameter int SHIFT_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               v1,
  input  logic               v2,
  input  logic [PSUM_W-1:0]  psum,
  input  logic [SCALE_W-1:0] scale,
  input  logic [SHIFT_W-1:0] shift,
  input  sat_mode_e          mode,
  output logic [ACT_W-1:0]   act
);
  localparam int PROD_W = PSUM_W + SCALE_W + 1;
  localparam int SUM_W  = PROD_W + 1;
  localparam logic signed [SUM_W-1:0] U_MAX = (SUM_W'(1) << ACT_W) - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] S_MAX = (SUM_W'(1) << (ACT_W-1)) - SUM_W'(1);
  localparam logic signed [SUM_W-1:0] S_MIN = -(SUM_W'(1) << (ACT_W-1));

  // stage 2: multiply
  logic signed [PSUM_W-1:0]  ps_s;
  logic signed [SCALE_W:0]   sc_s;
  logic signed [PROD_W-1:0]  prod_c, prod_q;
  logic [SHIFT_W-1:0]        shift_q;
  sat_mode_e                 mode_q;

  always_comb begin
    ps_s   = psum;
    sc_s   = {1'b0, scale};
    prod_c = PROD_W'(ps_s) * PROD_W'(sc_s);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q  <= '0;
      shift_q <= '0;
      mode_q  <= MODE_SIGNED;
    end else if (v1) begin
      prod_q  <= prod_c;
      shift_q <= shift;
      mode_q  <= mode;
    end
  end

  // stage 3: round, shift, saturate
  logic signed [SUM_W-1:0] rnd, sum, shr;
  logic [ACT_W-1:0]        sat;

  always_comb begin
    rnd = (shift_q == '0) ? '0 : (SUM_W'(1) << (shift_q - 1'b1));
    sum = SUM_W'(prod_q) + rnd;
    shr = sum >>> shift_q;
    if (mode_q == MODE_RELU) begin
      if (shr < 0)          sat = '0;
      else if (shr > U_MAX) sat = '1;
      else                  sat = shr[ACT_W-1:0];
    end else begin
      if (shr < S_MIN)      sat = {1'b1, {(ACT_W-1){1'b0}}};
      else if (shr > S_MAX) sat = {1'b0, {(ACT_W-1){1'b1}}};
      else                  sat = shr[ACT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     act <= '0;
    else if (v2) act <= sat;
  end
endmodule

// File: rtl/requant_unit.sv
module requant_unit
  import requant_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int PSUM_W  = 24,
  parameter int SCALE_W = 16,
  parameter int ACT_W   = 8,
  parameter int NUM_CH  = 64,
  parameter int SHIFT_W = 5,
  localparam int GROUPS = NUM_CH / LANES,
  localparam int ADDR_W = $clog2(NUM_CH),
  localparam int GRP_W  = $clog2(GROUPS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     scale_we,
  input  logic [ADDR_W-1:0]        scale_waddr,
  input  logic [SCALE_W-1:0]       scale_wdata,
  input  logic                     in_valid,
  input  logic [GRP_W-1:0]         in_group,
  input  logic [LANES*PSUM_W-1:0]  in_psum,
  input  logic [SHIFT_W-1:0]       shift_amt,
  input  logic                     relu_en,
  output logic                     out_valid,
  output logic [LANES*ACT_W-1:0]   out_act
);
  localparam int LANE_W = $clog2(LANES);

  // stage 1: scale read, beat capture
  logic                    v1, v2;
  logic [LANES*PSUM_W-1:0] psum_s1;
  logic [SHIFT_W-1:0]      shift_s1;
  sat_mode_e               mode_s1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1        <= 1'b0;
      v2        <= 1'b0;
      out_valid <= 1'b0;
      psum_s1   <= '0;
      shift_s1  <= '0;
      mode_s1   <= MODE_SIGNED;
    end else begin
      v1        <= in_valid;
      v2        <= v1;
      out_valid <= v2;
      if (in_valid) begin
        psum_s1  <= in_psum;
        shift_s1 <= shift_amt;
        mode_s1  <= relu_en ? MODE_RELU : MODE_SIGNED;
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SCALE_W-1:0] scale_s1;
    logic               bank_we;

    assign bank_we = scale_we && (scale_waddr[LANE_W-1:0] == LANE_W'(l));

    requant_scale_bank #(
      .DEPTH(GROUPS),
      .AW   (GRP_W),
      .DW   (SCALE_W)
    ) u_bank (
      .clk  (clk),
      .we   (bank_we),
      .waddr(scale_waddr[ADDR_W-1:LANE_W]),
      .wdata(scale_wdata),
      .re   (in_valid),
      .raddr(in_group),
      .rdata(scale_s1)
    );

    requant_lane #(
      .PSUM_W (PSUM_W),
      .SCALE_W(SCALE_W),
      .ACT_W  (ACT_W),
      .SHIFT_W(SHIFT_W)
    ) u_lane (
      .clk  (clk),
      .rst  (rst),
      .v1   (v1),
      .v2   (v2),
      .psum (psum_s1[l*PSUM_W +: PSUM_W]),
      .scale(scale_s1),
      .shift(shift_s1),
      .mode (mode_s1),
      .act  (out_act[l*ACT_W +: ACT_W])
    );
  end
endmodule

// File: rtl/requant_unit_chk.sv
module requant_unit_chk #(
  parameter int LANES  = 4,
  parameter int PSUM_W = 24,
  parameter int ACT_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic                    relu_en,
  input logic [LANES*PSUM_W-1:0] in_psum,
  input logic                    out_valid,
  input logic [LANES*ACT_W-1:0]  out_act
);
  logic [2:0]              vd, rd;
  logic [LANES*PSUM_W-1:0] pd [3];

  always_ff @(posedge clk) begin
    if (rst) begin
      vd <= '0;
      rd <= '0;
      for (int i = 0; i < 3; i++) pd[i] <= '0;
    end else begin
      vd    <= {vd[1:0], in_valid};
      rd    <= {rd[1:0], relu_en};
      pd[0] <= in_psum;
      pd[1] <= pd[0];
      pd[2] <= pd[1];
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid == vd[2]);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_act));

  for (genvar l = 0; l < LANES; l++) begin : g_chk
    logic signed [PSUM_W-1:0] ps;
    assign ps = pd[2][l*PSUM_W +: PSUM_W];

    p_zero_r5: assert property (@(posedge clk) disable iff (rst)
      (out_valid && ps == 0) |-> (out_act[l*ACT_W +: ACT_W] == '0));

    p_relu_neg_r6: assert property (@(posedge clk) disable iff (rst)
      (out_valid && rd[2] && ps < 0) |-> (out_act[l*ACT_W +: ACT_W] == '0));

    p_signed_pos_r7: assert property (@(posedge clk) disable iff (rst)
      (out_valid && !rd[2] && ps >= 0) |-> !out_act[l*ACT_W + ACT_W - 1]);
  end
endmodule

bind requant_unit requant_unit_chk #(
  .LANES (LANES),
  .PSUM_W(PSUM_W),
  .ACT_W (ACT_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .relu_en  (relu_en),
  .in_psum  (in_psum),
  .out_valid(out_valid),
  .out_act  (out_act)
);

// File: tb/requant_unit_tb.sv
module requant_unit_tb;
  localparam int LANES = 4, PSUM_W = 24, SCALE_W = 16, ACT_W = 8;
  localparam int NUM_CH = 64, SHIFT_W = 5, GROUPS = 16, GRP_W = 4, ADDR_W = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic scale_we = 1'b0;
  logic [ADDR_W-1:0] scale_waddr = '0;
  logic [SCALE_W-1:0] scale_wdata = '0;
  logic in_valid = 1'b0;
  logic [GRP_W-1:0] in_group = '0;
  logic [LANES*PSUM_W-1:0] in_psum = '0;
  logic [SHIFT_W-1:0] shift_amt = '0;
  logic relu_en = 1'b0;
  logic out_valid;
  logic [LANES*ACT_W-1:0] out_act;

  always #10 clk = ~clk;

  requant_unit u_dut (.*);

  typedef struct {
    bit                     v;
    string                  tag;
    logic [LANES*ACT_W-1:0] d;
  } exp_t;

  exp_t   q[$];
  longint scale_m [NUM_CH];
  longint cur_ps  [LANES];
  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint ref_act(longint p, longint s, int sh, bit relu);
    longint x = p * s;
    if (sh > 0) x += (64'sd1 <<< (sh - 1));
    x = x >>> sh;
    if (relu) begin
      if (x < 0) x = 0;
      if (x > 255) x = 255;
    end else begin
      if (x < -128) x = -128;
      if (x > 127) x = 127;
    end
    return x & 255;
  endfunction

  function automatic longint rnd_psum(longint lim);
    longint x = longint'($urandom) & 64'hFFFFFF;
    if (x >= (64'sd1 <<< 23)) x -= (64'sd1 <<< 24);
    if (lim > 0) x = x % lim;
    return x;
  endfunction

  // one beat: check the beat three cycles back, then drive and predict
  task automatic cycle(bit v, int grp, int sh, bit relu, bit we, int wa, longint wd, string tag);
    exp_t e;
    @(negedge clk);
    if (q.size() == 3) begin
      e = q.pop_front();
      chk(out_valid == e.v, {e.tag, " valid"}, out_valid, e.v);
      if (e.v)
        for (int l = 0; l < LANES; l++)
          chk(out_act[l*ACT_W +: ACT_W] == e.d[l*ACT_W +: ACT_W],
              $sformatf("%s lane%0d", e.tag, l),
              out_act[l*ACT_W +: ACT_W], e.d[l*ACT_W +: ACT_W]);
    end
    in_valid  = v;
    in_group  = GRP_W'(grp);
    shift_amt = SHIFT_W'(sh);
    relu_en   = relu;
    for (int l = 0; l < LANES; l++) in_psum[l*PSUM_W +: PSUM_W] = PSUM_W'(cur_ps[l]);
    scale_we    = we;
    scale_waddr = ADDR_W'(wa);
    scale_wdata = SCALE_W'(wd);
    e.v = v;
    e.tag = tag;
    e.d = '0;
    if (v)
      for (int l = 0; l < LANES; l++)
        e.d[l*ACT_W +: ACT_W] = ACT_W'(ref_act(cur_ps[l], scale_m[grp*LANES + l], sh, relu));
    q.push_back(e);
    if (we) scale_m[wa] = wd;
  endtask

  task automatic beat(int grp, int sh, bit relu, string tag);
    cycle(1'b1, grp, sh, relu, 1'b0, 0, 0, tag);
  endtask

  task automatic idle(string tag);
    cycle(1'b0, 0, 0, 1'b0, 1'b0, 0, 0, tag);
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) cur_ps[l] = 0;
    // R1: reset state
    repeat (4) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
      chk(out_act == '0, "R1 act in reset", out_act, 0);
    end
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    chk(out_act == '0, "R1 act after reset", out_act, 0);

    // R4: load every channel with a distinct scale
    for (int a = 0; a < NUM_CH; a++) begin
      longint s = (a * 2731 + 517) & 16'hFFFF;
      if (a == 5) s = 0;
      if (a == 9) s = 16'hFFFF;
      cycle(1'b0, 0, 0, 1'b0, 1'b1, a, s, "R4 load");
    end

    // R3: every group, per-lane scale address
    for (int g = 0; g < GROUPS; g++) begin
      for (int l = 0; l < LANES; l++) cur_ps[l] = 1000 + g * 37 + l * 11;
      beat(g, 8, 1'b1, "R3 addressing");
    end

    // R5: rounding at small shifts, zero sums, shift limits
    for (int i = 0; i < 60; i++) begin
      int sh;
      sh = (i % 5 == 0) ? 0 : (i % 5 == 1) ? 1 : (i % 5 == 2) ? 8 : (i % 5 == 3) ? 16 : 31;
      for (int l = 0; l < LANES; l++) cur_ps[l] = (i % 7 == 0) ? 0 : rnd_psum(300);
      beat(i % GROUPS, sh, 1'b0, "R5 rounding");
    end

    // R6: unsigned clamp, full-range sums
    for (int i = 0; i < 40; i++) begin
      for (int l = 0; l < LANES; l++) cur_ps[l] = rnd_psum(0);
      beat($urandom % GROUPS, 18 + (i % 6), 1'b1, "R6 relu clamp");
    end

    // R7: signed clamp, full-range sums
    for (int i = 0; i < 40; i++) begin
      for (int l = 0; l < LANES; l++) cur_ps[l] = rnd_psum(0);
      beat($urandom % GROUPS, 18 + (i % 6), 1'b0, "R7 signed clamp");
    end

    // R2: bubbles in the stream
    for (int i = 0; i < 60; i++) begin
      for (int l = 0; l < LANES; l++) cur_ps[l] = rnd_psum(20000);
      if ($urandom % 2) beat($urandom % GROUPS, 12, 1'b1, "R2 bubbles");
      else idle("R2 bubbles");
    end

    // R8: mode and shift change on every beat
    for (int i = 0; i < 40; i++) begin
      for (int l = 0; l < LANES; l++) cur_ps[l] = rnd_psum(50000);
      beat($urandom % GROUPS, (i % 2) ? 10 : 14, i % 2, "R8 per-beat mode");
    end

    // R4: rewrite a scale, then use it on the next cycle
    for (int l = 0; l < LANES; l++) cur_ps[l] = 3000 + l;
    cycle(1'b0, 0, 0, 1'b0, 1'b1, 6, 16'h0400, "R4 rewrite");
    beat(1, 4, 1'b1, "R4 new scale");
    cycle(1'b0, 0, 0, 1'b0, 1'b1, 6, 16'h0001, "R4 rewrite");
    beat(1, 0, 1'b0, "R4 new scale");

    repeat (4) idle("drain");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule